// File: doc/BRIEF.md
# Interrupt Vector Relocation Controller

This block owns the control byte that chooses where the interrupt vector table lives in program memory. With the selection bit clear, the table starts at word address zero. With it set, the table starts at the first word of the boot-loader region, and that address follows from a 2-bit boot-size code. To flip the selection bit, software must first arm a change-enable bit. It then has a four-cycle window in which a second write carrying the new selection, with change-enable written as zero, takes effect. Any other selection write is ignored.

While the window is armed, the block raises an interrupt-block output toward the interrupt logic. That mask stays up for one more cycle after an accepted selection write, which covers the instruction that follows it. The mask never changes the processor's global interrupt flag. The same output also blocks interrupts when execution sits in a region that a programmed lock bit protects from the vectors' region. The byte also holds two external-interrupt enable bits that ride along on every write.

Top module: `ivec_reloc_ctrl`

## Requirements
- R1: After reset, rd_data reads 0x00, vec_base is 0 and irq_block is 0 while both lock inputs are 0.
- R2: rd_data packs the byte as follows: bit 7 is external enable 1, bit 6 is external enable 0, bits 5..2 read 0, bit 1 is the selection bit and bit 0 is change-enable. Every write loads bits 7 and 6 from wr_data.
- R3: A write with wr_data[0]=1 sets change-enable and opens a window of four cycles. That write leaves the selection bit unchanged. Arming again while the window is open restarts the full window.
- R4: A write with wr_data[0]=0 while change-enable is clear, including any write after the window has closed, leaves the selection bit unchanged.
- R5: A write with wr_data[0]=0 in any of the four window cycles copies wr_data[1] into the selection bit and clears change-enable. Both show on rd_data one cycle later.
- R6: If no accepted write arrives, change-enable reads 1 for exactly four cycles after the arming edge and then reads 0.
- R7: irq_block is 1 in every cycle where change-enable is set, and in the one cycle after an accepted selection write. The block has no port that touches the global interrupt flag.
- R8: vec_base is 0 when the selection bit is 0. When it is 1, vec_base is 2^PC_W − (2^BOOT_MAX_LOG2 >> boot_size). With the defaults, codes 0, 1, 2 and 3 give 0xC00, 0xE00, 0xF00 and 0xF80.
- R9: When the selection bit is 1 and boot_lock is 1, irq_block is 1 whenever pc is below the boot start (the application region).
- R10: When the selection bit is 0 and app_lock is 1, irq_block is 1 whenever pc is at or above the boot start (the boot region).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current control byte |
| pc | input | PC_W | Program counter (word address) |
| boot_size | input | 2 | Boot-region size code |
| boot_lock | input | 1 | Boot-section lock programmed |
| app_lock | input | 1 | Application-section lock programmed |
| vec_base | output | PC_W | Vector table base word address |
| irq_block | output | 1 | Interrupts must not be taken |

## Verification
Register results (rd_data, the arming mask and the post-write mask cycle) are due one clock edge after the write that causes them. vec_base follows the selection register plus the combinational boot-size decode, so it is also due at that edge. The lock gating on irq_block follows pc, boot_size and the lock inputs in the same cycle. The bench drives every input on the falling edge and queues the expected byte, base and mask for that step. A monitor pops the entry 5 ns after the next rising edge, which is the first point where all three results are settled. The window is probed by counting steps: a write in the fourth armed cycle is accepted, and a write one cycle later is not.

// File: rtl/ivec_reloc_pkg.sv
package ivec_reloc_pkg;
   // Bit positions inside the control byte (decoded by software, fixed)
   localparam int unsigned CTL_W    = 8;
   localparam int unsigned BIT_CE   = 0;
   localparam int unsigned BIT_SEL  = 1;
   localparam int unsigned BIT_EXT0 = 6;
   localparam int unsigned BIT_EXT1 = 7;
   localparam int unsigned N_SIZES  = 4;

   typedef struct packed {
      logic sel;
      logic armed;
      logic tail;
   } ivec_state_t;
endpackage

// File: rtl/ivec_unlock_seq.sv
module ivec_unlock_seq #(
   parameter int unsigned WINDOW_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_ce,
   input  logic wr_sel,
   output ivec_reloc_pkg::ivec_state_t st_o
);
   localparam int unsigned CNT_W = (WINDOW_CYC > 1) ? $clog2(WINDOW_CYC) : 1;
   localparam int unsigned AGE_W = CNT_W + 2;

   if (WINDOW_CYC < 1) begin : g_bad_window
      $error("WINDOW_CYC must be at least 1");
   end

   logic armed_q, sel_q, tail_q;
   logic arm, accept, expire;

   assign arm    = wr_en & wr_ce;
   assign accept = wr_en & armed_q & ~wr_ce;

   if (WINDOW_CYC == 1) begin : g_no_cnt
      assign expire = 1'b1;
   end else begin : g_cnt
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        cnt_q <= '0;
         else if (arm)                      cnt_q <= CNT_W'(WINDOW_CYC - 1);
         else if (armed_q && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      end
      assign expire = (cnt_q == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         sel_q   <= 1'b0;
         tail_q  <= 1'b0;
      end else begin
         tail_q <= accept;
         if (accept) sel_q <= wr_sel;
         if (arm)                     armed_q <= 1'b1;
         else if (accept)             armed_q <= 1'b0;
         else if (armed_q && expire)  armed_q <= 1'b0;
      end
   end

   assign st_o.sel   = sel_q;
   assign st_o.armed = armed_q;
   assign st_o.tail  = tail_q;

   // Independent age counter bounding the window length
   logic [AGE_W-1:0] age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       age_q <= '0;
      else if (arm)     age_q <= AGE_W'(1);
      else if (armed_q) age_q <= age_q + 1'b1;
      else              age_q <= '0;
   end

   p_window_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> (age_q <= AGE_W'(WINDOW_CYC)));

   p_sel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_q |=> $stable(sel_q));

   p_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && wr_en && !wr_ce) |=> (sel_q == $past(wr_sel)) && !armed_q);
endmodule

// File: rtl/ivec_boot_map.sv
module ivec_boot_map #(
   parameter int unsigned PC_W          = 12,
   parameter int unsigned BOOT_MAX_LOG2 = 10
) (
   input  logic [1:0]      size_code,
   output logic [PC_W-1:0] boot_start
);
   if (BOOT_MAX_LOG2 >= PC_W || BOOT_MAX_LOG2 < 3) begin : g_bad_size
      $error("BOOT_MAX_LOG2 must lie in [3, PC_W-1]");
   end

   localparam logic [PC_W:0] TOP_V = (PC_W+1)'(1) << PC_W;

   logic [PC_W-1:0] starts [ivec_reloc_pkg::N_SIZES];

   for (genvar i = 0; i < int'(ivec_reloc_pkg::N_SIZES); i++) begin : g_start
      localparam logic [PC_W:0] WORDS = (PC_W+1)'(1) << (BOOT_MAX_LOG2 - i);
      assign starts[i] = PC_W'(TOP_V - WORDS);
   end

   assign boot_start = starts[size_code];
endmodule

// File: rtl/ivec_exec_gate.sv
module ivec_exec_gate #(
   parameter int unsigned PC_W = 12
) (
   input  logic [PC_W-1:0] pc,
   input  logic [PC_W-1:0] boot_start,
   input  logic            sel,
   input  logic            boot_lock,
   input  logic            app_lock,
   output logic            lock_block,
   output logic [PC_W-1:0] vec_base
);
   logic in_boot;

   assign in_boot    = (pc >= boot_start);
   assign lock_block = (sel & boot_lock & ~in_boot) | (~sel & app_lock & in_boot);
   assign vec_base   = sel ? boot_start : '0;
endmodule

// File: rtl/ivec_reloc_ctrl.sv
module ivec_reloc_ctrl #(
   parameter int unsigned PC_W          = 12,
   parameter int unsigned BOOT_MAX_LOG2 = 10,
   parameter int unsigned WINDOW_CYC    = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [7:0]      wr_data,
   output logic [7:0]      rd_data,
   input  logic [PC_W-1:0] pc,
   input  logic [1:0]      boot_size,
   input  logic            boot_lock,
   input  logic            app_lock,
   output logic [PC_W-1:0] vec_base,
   output logic            irq_block
);
   import ivec_reloc_pkg::*;

   ivec_state_t     st;
   logic [1:0]      ext_q;
   logic [PC_W-1:0] boot_start;
   logic            lock_block;

   ivec_unlock_seq #(.WINDOW_CYC(WINDOW_CYC)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_ce  (wr_data[BIT_CE]),
      .wr_sel (wr_data[BIT_SEL]),
      .st_o   (st)
   );

   ivec_boot_map #(.PC_W(PC_W), .BOOT_MAX_LOG2(BOOT_MAX_LOG2)) u_map (
      .size_code  (boot_size),
      .boot_start (boot_start)
   );

   ivec_exec_gate #(.PC_W(PC_W)) u_gate (
      .pc         (pc),
      .boot_start (boot_start),
      .sel        (st.sel),
      .boot_lock  (boot_lock),
      .app_lock   (app_lock),
      .lock_block (lock_block),
      .vec_base   (vec_base)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ext_q <= 2'b00;
      else if (wr_en) ext_q <= {wr_data[BIT_EXT1], wr_data[BIT_EXT0]};
   end

   always_comb begin
      rd_data           = '0;
      rd_data[BIT_EXT1] = ext_q[1];
      rd_data[BIT_EXT0] = ext_q[0];
      rd_data[BIT_SEL]  = st.sel;
      rd_data[BIT_CE]   = st.armed;
   end

   assign irq_block = st.armed | st.tail | lock_block;

   p_arm_sets_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[0]) |=> rd_data[0] && irq_block);

   p_mask_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[0] |-> irq_block);

   p_tail_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[0] && wr_en && !wr_data[0]) |=> irq_block);

   p_base_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[1] |-> (vec_base == '0));

   p_app_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[1] && boot_lock && pc < boot_start) |-> irq_block);

   p_boot_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_data[1] && app_lock && pc >= boot_start) |-> irq_block);
endmodule

// File: tb/ivec_reloc_ctrl_tb.sv
module ivec_reloc_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = '0;
   logic [7:0]  rd_data;
   logic [11:0] pc = 12'h100;
   logic [1:0]  boot_size = 2'd0;
   logic        boot_lock = 1'b0;
   logic        app_lock = 1'b0;
   logic [11:0] vec_base;
   logic        irq_block;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   typedef struct {
      logic [7:0]  rd;
      logic [11:0] base;
      logic        blk;
      string       tag;
   } exp_t;
   exp_t q[$];

   always #10 clk = ~clk;

   ivec_reloc_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .pc(pc), .boot_size(boot_size),
      .boot_lock(boot_lock), .app_lock(app_lock),
      .vec_base(vec_base), .irq_block(irq_block)
   );

   task automatic step(input logic we, input logic [7:0] d, input logic [11:0] pcv,
                       input logic [1:0] bs, input logic lb, input logic la,
                       input logic [7:0] erd, input logic [11:0] eb, input logic eblk,
                       input string tag);
      exp_t e;
      @(negedge clk);
      wr_en = we; wr_data = d; pc = pcv; boot_size = bs;
      boot_lock = lb; app_lock = la;
      e.rd = erd; e.base = eb; e.blk = eblk; e.tag = tag;
      q.push_back(e);
   endtask

   // Monitor: compares 5 ns after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (rd_data !== e.rd || vec_base !== e.base || irq_block !== e.blk) begin
               n_bad++;
               $display("FAIL %s: got rd=%02h base=%03h blk=%0b, expected rd=%02h base=%03h blk=%0b",
                        e.tag, rd_data, vec_base, irq_block, e.rd, e.base, e.blk);
            end
         end
      end
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      step(0, 8'h00, 12'h100, 0, 0, 0, 8'h00, 12'h000, 0, "R1 reset");
      // R4 select write without arming
      step(1, 8'h02, 12'h100, 0, 0, 0, 8'h00, 12'h000, 0, "R4 unarmed write");
      // R3/R2 arm with ext enables
      step(1, 8'hC1, 12'h100, 0, 0, 0, 8'hC1, 12'h000, 1, "R3 arm");
      step(0, 8'h00, 12'h100, 0, 0, 0, 8'hC1, 12'h000, 1, "R7 armed mask");
      // R5 accepted write, R7 tail cycle, R8 base
      step(1, 8'hC2, 12'h100, 0, 0, 0, 8'hC2, 12'hC00, 1, "R5 accept");
      step(0, 8'h00, 12'h100, 0, 0, 0, 8'hC2, 12'hC00, 0, "R7 tail ends");
      // R6 timeout
      step(1, 8'h01, 12'h100, 0, 0, 0, 8'h03, 12'hC00, 1, "R2 ext cleared R3 arm");
      step(0, 8'h00, 12'h100, 0, 0, 0, 8'h03, 12'hC00, 1, "R6 cycle2");
      step(0, 8'h00, 12'h100, 0, 0, 0, 8'h03, 12'hC00, 1, "R6 cycle3");
      step(0, 8'h00, 12'h100, 0, 0, 0, 8'h03, 12'hC00, 1, "R6 cycle4");
      step(0, 8'h00, 12'h100, 0, 0, 0, 8'h02, 12'hC00, 0, "R6 expired");
      step(1, 8'h00, 12'h100, 0, 0, 0, 8'h02, 12'hC00, 0, "R4 late write");
      // R5 write in the fourth window cycle
      step(1, 8'h01, 12'h100, 0, 0, 0, 8'h03, 12'hC00, 1, "R3 arm again");
      step(0, 8'h00, 12'h100, 0, 0, 0, 8'h03, 12'hC00, 1, "R6 c2");
      step(0, 8'h00, 12'h100, 0, 0, 0, 8'h03, 12'hC00, 1, "R6 c3");
      step(0, 8'h00, 12'h100, 0, 0, 0, 8'h03, 12'hC00, 1, "R6 c4");
      step(1, 8'h00, 12'h100, 0, 0, 0, 8'h00, 12'h000, 1, "R5 last-cycle write");
      step(0, 8'h00, 12'h100, 0, 0, 0, 8'h00, 12'h000, 0, "R7 tail over");
      // R3 re-arm restarts window
      step(1, 8'h01, 12'h100, 0, 0, 0, 8'h01, 12'h000, 1, "R3 arm");
      step(0, 8'h00, 12'h100, 0, 0, 0, 8'h01, 12'h000, 1, "R3 c2");
      step(1, 8'h01, 12'h100, 0, 0, 0, 8'h01, 12'h000, 1, "R3 rearm");
      step(0, 8'h00, 12'h100, 0, 0, 0, 8'h01, 12'h000, 1, "R3 rearm c2");
      step(0, 8'h00, 12'h100, 0, 0, 0, 8'h01, 12'h000, 1, "R3 rearm c3");
      step(0, 8'h00, 12'h100, 0, 0, 0, 8'h01, 12'h000, 1, "R3 rearm c4");
      step(0, 8'h00, 12'h100, 0, 0, 0, 8'h00, 12'h000, 0, "R6 rearm expired");
      // R10 application-section lock
      step(0, 8'h00, 12'h100, 0, 0, 1, 8'h00, 12'h000, 0, "R10 pc in app");
      step(0, 8'h00, 12'hC00, 0, 0, 1, 8'h00, 12'h000, 1, "R10 pc in boot");
      step(0, 8'h00, 12'hC00, 1, 0, 1, 8'h00, 12'h000, 0, "R10 smaller boot");
      // Move vectors to boot with size code 3
      step(1, 8'h01, 12'h100, 3, 0, 0, 8'h01, 12'h000, 1, "R3 arm");
      step(1, 8'h02, 12'h100, 3, 0, 0, 8'h02, 12'hF80, 1, "R8 base code3");
      step(0, 8'h00, 12'h100, 3, 0, 0, 8'h02, 12'hF80, 0, "R7 tail over");
      // R9 boot-section lock
      step(0, 8'h00, 12'h100, 3, 1, 0, 8'h02, 12'hF80, 1, "R9 pc in app");
      step(0, 8'h00, 12'hF80, 3, 1, 0, 8'h02, 12'hF80, 0, "R9 pc at boot start");
      step(0, 8'h00, 12'hF7F, 3, 1, 0, 8'h02, 12'hF80, 1, "R9 pc below boundary");
      // R8 other size codes
      step(0, 8'h00, 12'h100, 2, 0, 0, 8'h02, 12'hF00, 0, "R8 base code2");
      step(0, 8'h00, 12'h100, 1, 0, 0, 8'h02, 12'hE00, 0, "R8 base code1");
      step(0, 8'h00, 12'h100, 0, 0, 0, 8'h02, 12'hC00, 0, "R8 base code0");
      @(negedge clk);
      wr_en = 1'b0;
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule